// File: doc/BRIEF.md
# Widening Vector Multiply-Accumulate Unit

This block executes a family of eight widening multiply-accumulate operations on a fixed-length vector datapath. A 32-bit instruction word arrives together with three vector operands: an accumulator and two multiplicand sources. The block decodes the word and forms every wide destination lane in the same cycle. For each lane it picks one half-width element from each source, at either the even or the odd narrow position. It extends both elements as signed or unsigned and multiplies them. The product is then added to the accumulator lane or subtracted from it, and the result wraps modulo the lane width.

The operation starts with a one-cycle `start_i` pulse. One cycle later the unit presents the updated accumulator vector, a one-cycle `done_o` strobe, an illegal-encoding flag and the three decoded register indices. All of these outputs are registered. An encoding outside the group, or one that asks for 8-bit destination lanes, is flagged as illegal, and the accumulator then passes through unchanged.

Top module: `wmac_unit`

## Requirements
- R1: After reset, and until the first operation completes, `done_o` and `illegal_o` are 0 and `result_o` is all zeros.
- R2: `done_o` is 1 in exactly the cycle after a cycle with `start_i` high, and 0 in every other cycle. Without a start, `result_o` holds its value.
- R3: An encoding is legal only when bits [31:24] are 8'h44, bit 21 is 0 and bits [15:13] are 3'b010. Any other word sets `illegal_o` together with `done_o`, and `illegal_o` is never high without `done_o`.
- R4: A size field (bits [23:22]) of 0 is illegal. For every illegal word, `result_o` equals the accumulator input unchanged.
- R5: Bit 10 selects the narrow elements. When it is 0, destination lane i uses narrow element 2i of both sources (the low half of the lane). When it is 1, lane i uses element 2i+1 (the high half).
- R6: When bit 11 is 0, both narrow operands are sign-extended before the multiply.
- R7: When bit 11 is 1, both narrow operands are zero-extended before the multiply.
- R8: When bit 12 is 1, the full product is subtracted from the accumulator lane. When it is 0, the product is added.
- R9: The accumulate wraps modulo 2^lane-width, with no saturation.
- R10: `rd_idx_o`, `rn_idx_o` and `rm_idx_o` present instruction bits [4:0], [9:5] and [20:16] of the started word, registered with `done_o`.
- R11: A size of 1, 2 or 3 gives destination lanes of 16, 32 or 64 bits, built from 8-, 16- or 32-bit sources, and all lanes of the vector are processed in the same operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle operation start |
| insn_i | input | 32 | Instruction word |
| acc_i | input | VLEN | Accumulator vector |
| srca_i | input | VLEN | First multiplicand vector |
| srcb_i | input | VLEN | Second multiplicand vector |
| result_o | output | VLEN | Updated accumulator vector |
| done_o | output | 1 | Result valid strobe |
| illegal_o | output | 1 | Encoding not supported |
| rd_idx_o | output | 5 | Destination/accumulator register index |
| rn_idx_o | output | 5 | First source register index |
| rm_idx_o | output | 5 | Second source register index |

## Verification
The assertions assume that `insn_i` and the operand vectors are stable and known in every cycle where `start_i` is high. They make no assumption about back-to-back starts, so a start may arrive in the cycle right after another one. The bench drives all inputs at the falling edge and samples at the next falling edge, so each start is a clean single-cycle pulse with defined operands. It sweeps every size and every variant over extreme and random operands, and adds each kind of malformed word.

// File: rtl/wmac_pkg.sv
// Package: shared encodings and the decoded-operation type for the
// widening multiply-accumulate unit. Assumes 32-bit instruction words.
package wmac_pkg;

    localparam logic [7:0] GRP_MAJOR = 8'h44;   // bits [31:24]
    localparam logic [2:0] GRP_MINOR = 3'b010;  // bits [15:13]

    typedef struct packed {
        logic       legal;
        logic [1:0] size;
        logic       is_sub;
        logic       is_uns;
        logic       is_top;
        logic [4:0] rd;
        logic [4:0] rn;
        logic [4:0] rm;
    } wmac_op_t;

endpackage

// File: rtl/wmac_decode.sv
// Module: wmac_decode
// Purely combinational decoder. It checks the fixed group bits, rejects
// size 0, and splits out the variant flags and register indices.
// Assumes nothing about the word; any pattern gives a defined result.
module wmac_decode
    import wmac_pkg::*;
(
    input  logic [31:0] insn_i,
    output wmac_op_t    op_o
);

    logic grp_match;

    // Group match on the fixed opcode fields.
    always_comb begin
        grp_match = (insn_i[31:24] == GRP_MAJOR) &&
                    (insn_i[21] == 1'b0) &&
                    (insn_i[15:13] == GRP_MINOR);
    end

    // Field extraction and legality.
    always_comb begin
        op_o.size   = insn_i[23:22];
        op_o.legal  = grp_match && (insn_i[23:22] != 2'd0);
        op_o.is_sub = insn_i[12];
        op_o.is_uns = insn_i[11];
        op_o.is_top = insn_i[10];
        op_o.rd     = insn_i[4:0];
        op_o.rn     = insn_i[9:5];
        op_o.rm     = insn_i[20:16];
    end

endmodule

// File: rtl/wmac_lane.sv
// Module: wmac_lane
// One destination lane of width DW. It extends two half-width operands,
// multiplies them and adds the product to, or subtracts it from, the
// accumulator, wrapping modulo 2^DW. A DW-bit product of the extended
// operands holds the exact low DW bits in both signed and unsigned modes.
module wmac_lane #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   acc_i,
    input  logic [DW/2-1:0] a_i,
    input  logic [DW/2-1:0] b_i,
    input  logic            uns_i,
    input  logic            sub_i,
    output logic [DW-1:0]   sum_o
);

    localparam int HW = DW / 2;

    logic [DW-1:0] ext_a;
    logic [DW-1:0] ext_b;
    logic [DW-1:0] prod;

    // Operand extension by signedness.
    always_comb begin
        ext_a = {{HW{~uns_i & a_i[HW-1]}}, a_i};
        ext_b = {{HW{~uns_i & b_i[HW-1]}}, b_i};
    end

    // Multiply, then accumulate or subtract with wrap-around.
    always_comb begin
        prod  = ext_a * ext_b;
        sum_o = sub_i ? (acc_i - prod) : (acc_i + prod);
    end

endmodule

// File: rtl/wmac_lane_array.sv
// Module: wmac_lane_array
// Every DW-wide lane of a VLEN-bit vector. Each lane takes the low
// (even) or high (odd) narrow element of its slice in both sources.
// Assumes VLEN is a multiple of DW.
module wmac_lane_array #(
    parameter int VLEN = 128,
    parameter int DW   = 16
) (
    input  logic [VLEN-1:0] acc_i,
    input  logic [VLEN-1:0] srca_i,
    input  logic [VLEN-1:0] srcb_i,
    input  logic            uns_i,
    input  logic            sub_i,
    input  logic            top_i,
    output logic [VLEN-1:0] res_o
);

    localparam int HW    = DW / 2;
    localparam int LANES = VLEN / DW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [HW-1:0] na;
        logic [HW-1:0] nb;

        // Narrow element pick: element 2i or 2i+1.
        always_comb begin
            na = top_i ? srca_i[i*DW+HW +: HW] : srca_i[i*DW +: HW];
            nb = top_i ? srcb_i[i*DW+HW +: HW] : srcb_i[i*DW +: HW];
        end

        wmac_lane #(.DW(DW)) lane_i (
            .acc_i (acc_i[i*DW +: DW]),
            .a_i   (na),
            .b_i   (nb),
            .uns_i (uns_i),
            .sub_i (sub_i),
            .sum_o (res_o[i*DW +: DW])
        );
    end

endmodule

// File: rtl/wmac_unit.sv
// Module: wmac_unit (top)
// Widening vector multiply-accumulate. It decodes the word, computes the
// 16-, 32- and 64-bit lane arrays side by side and registers the array
// chosen by size, one cycle after start. An illegal word passes the
// accumulator through. Assumes VLEN is a multiple of 64 and that the
// inputs are stable while start_i is high.
module wmac_unit
    import wmac_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [31:0]     insn_i,
    input  logic [VLEN-1:0] acc_i,
    input  logic [VLEN-1:0] srca_i,
    input  logic [VLEN-1:0] srcb_i,
    output logic [VLEN-1:0] result_o,
    output logic            done_o,
    output logic            illegal_o,
    output logic [4:0]      rd_idx_o,
    output logic [4:0]      rn_idx_o,
    output logic [4:0]      rm_idx_o
);

    localparam int NSIZE = 3;

    wmac_op_t        op;
    logic [VLEN-1:0] by_size [1:NSIZE];
    logic [VLEN-1:0] next_res;

    wmac_decode dec_i (
        .insn_i (insn_i),
        .op_o   (op)
    );

    for (genvar s = 1; s <= NSIZE; s++) begin : g_size
        wmac_lane_array #(.VLEN(VLEN), .DW(8 << s)) arr_i (
            .acc_i  (acc_i),
            .srca_i (srca_i),
            .srcb_i (srcb_i),
            .uns_i  (op.is_uns),
            .sub_i  (op.is_sub),
            .top_i  (op.is_top),
            .res_o  (by_size[s])
        );
    end

    // Select the lane array for the decoded size; pass through if illegal.
    always_comb begin
        next_res = acc_i;
        if (op.legal) begin
            case (op.size)
                2'd1:    next_res = by_size[1];
                2'd2:    next_res = by_size[2];
                2'd3:    next_res = by_size[3];
                default: next_res = acc_i;
            endcase
        end
    end

    // Output registers: the done strobe and its flag every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            done_o    <= start_i;
            illegal_o <= start_i & ~op.legal;
        end
    end

    // Output registers: result and indices, loaded on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            rd_idx_o <= '0;
            rn_idx_o <= '0;
            rm_idx_o <= '0;
        end else if (start_i) begin
            result_o <= next_res;
            rd_idx_o <= op.rd;
            rn_idx_o <= op.rn;
            rm_idx_o <= op.rm;
        end
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o); // R2
    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!done_o && $stable(result_o))); // R2
    AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> done_o); // R3
    AST_SIZE0_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && insn_i[23:22] == 2'd0) |=> illegal_o); // R4
    AST_ILLEGAL_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && insn_i[31:24] != 8'h44) |=> (result_o == $past(acc_i))); // R4
    AST_RD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (rd_idx_o == $past(insn_i[4:0]))); // R10

endmodule

// File: tb/wmac_unit_tb_top.sv
// Bench: sweeps every size and variant over extreme and random operands,
// plus malformed words, with expected vectors computed arithmetically.
module wmac_unit_tb_top;

    localparam int VLEN = 128;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [31:0]     insn_i = '0;
    logic [VLEN-1:0] acc_i = '0, srca_i = '0, srcb_i = '0;
    logic [VLEN-1:0] result_o;
    logic            done_o, illegal_o;
    logic [4:0]      rd_idx_o, rn_idx_o, rm_idx_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    wmac_unit #(.VLEN(VLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
        .acc_i(acc_i), .srca_i(srca_i), .srcb_i(srcb_i),
        .result_o(result_o), .done_o(done_o), .illegal_o(illegal_o),
        .rd_idx_o(rd_idx_o), .rn_idx_o(rn_idx_o), .rm_idx_o(rm_idx_o)
    );

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic [2:0] var3,
                                       input logic [4:0] rd, input logic [4:0] rn,
                                       input logic [4:0] rm);
        return {8'h44, sz, 1'b0, rm, 3'b010, var3, rn, rd};
    endfunction

    // Expected vector from the requirements (legal words only).
    function automatic logic [VLEN-1:0] model(input logic [1:0] sz, input logic [2:0] v,
                                              input logic [VLEN-1:0] acc,
                                              input logic [VLEN-1:0] a,
                                              input logic [VLEN-1:0] b);
        logic [VLEN-1:0] r;
        int dw, hw;
        logic [63:0] mh, md, x, y, p, s, ac;
        r  = '0;
        dw = 8 << sz;
        hw = dw / 2;
        mh = (64'd1 << hw) - 64'd1;
        md = (dw == 64) ? ~64'd0 : ((64'd1 << dw) - 64'd1);
        for (int i = 0; i < VLEN / dw; i++) begin
            x  = 64'(a >> (i*dw + (v[0] ? hw : 0))) & mh;
            y  = 64'(b >> (i*dw + (v[0] ? hw : 0))) & mh;
            ac = 64'(acc >> (i*dw)) & md;
            if (!v[1] && x[hw-1]) x = x | ~mh;
            if (!v[1] && y[hw-1]) y = y | ~mh;
            p = x * y;
            s = (v[2] ? (ac - p) : (ac + p)) & md;
            r = r | (VLEN'(s) << (i*dw));
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one operation and sample one cycle later.
    task automatic run(input logic [31:0] w, input logic [VLEN-1:0] acc,
                       input logic [VLEN-1:0] a, input logic [VLEN-1:0] b);
        @(negedge clk);
        start_i = 1'b1; insn_i = w; acc_i = acc; srca_i = a; srcb_i = b;
        @(negedge clk);
        start_i = 1'b0;
        insn_i = $urandom; acc_i = {4{$urandom}}; srca_i = {4{$urandom}};
    endtask

    task automatic legal_op(input logic [1:0] sz, input logic [2:0] v,
                            input logic [VLEN-1:0] acc, input logic [VLEN-1:0] a,
                            input logic [VLEN-1:0] b, input string tag);
        logic [31:0] w;
        w = mk(sz, v, 5'($urandom), 5'($urandom), 5'($urandom));
        run(w, acc, a, b);
        chk("R2 done", VLEN'(done_o), VLEN'(1));
        chk("R3 legal", VLEN'(illegal_o), VLEN'(0));
        chk(tag, result_o, model(sz, v, acc, a, b));
        chk("R10 idx", VLEN'({rd_idx_o, rn_idx_o, rm_idx_o}),
            VLEN'({w[4:0], w[9:5], w[20:16]}));
    endtask

    task automatic bad_op(input logic [31:0] w, input string tag);
        logic [VLEN-1:0] acc;
        acc = {$urandom, $urandom, $urandom, $urandom};
        run(w, acc, {4{$urandom}}, {4{$urandom}});
        chk({tag, " flag"}, VLEN'({done_o, illegal_o}), VLEN'(2'b11));
        chk("R4 acc kept", result_o, acc);
    endtask

    function automatic logic [VLEN-1:0] pick(input int k);
        case (k)
            0: return '0;
            1: return '1;
            2: return {16{8'h80}};
            3: return {16{8'h7f}};
            default: return {$urandom, $urandom, $urandom, $urandom};
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [VLEN-1:0] prev;
        repeat (3) @(negedge clk);
        chk("R1 reset", {result_o[VLEN-4:0], done_o, illegal_o, 1'b0}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {result_o[VLEN-3:0], done_o, illegal_o}, '0);

        // Sweep sizes, variants and operand patterns.
        for (int sz = 1; sz <= 3; sz++)
            for (int v = 0; v < 8; v++)
                for (int k = 0; k < 12; k++) begin
                    string tg;
                    tg = v[2] ? "R8 sub" : (v[1] ? "R7 unsigned" : "R6 signed");
                    legal_op(2'(sz), 3'(v), pick(k % 6), pick((k + 2) % 6),
                             pick((k + 3) % 6), {tg, " R11"});
                end

        // R2: no start means no done and held result.
        legal_op(2'd2, 3'd0, pick(4), pick(4), pick(4), "R6 signed");
        prev = result_o;
        @(negedge clk);
        chk("R2 idle done", VLEN'(done_o), VLEN'(0));
        chk("R2 hold", result_o, prev);

        // R5: bottom and top pick differ.
        run(mk(2'd1, 3'b010, 0, 0, 0), '0, {8{16'h0302}}, {8{16'h0504}});
        chk("R5 bottom", result_o, {8{16'd8}});
        run(mk(2'd1, 3'b011, 0, 0, 0), '0, {8{16'h0302}}, {8{16'h0504}});
        chk("R5 top", result_o, {8{16'd15}});

        // R6/R7: same bits, different extension.
        run(mk(2'd1, 3'b000, 0, 0, 0), '0, {8{16'h00ff}}, {8{16'h00ff}});
        chk("R6 sign ext", result_o, {8{16'd1}});
        run(mk(2'd1, 3'b010, 0, 0, 0), '0, {8{16'h00ff}}, {8{16'h00ff}});
        chk("R7 zero ext", result_o, {8{16'hfe01}});

        // R8: subtract product.
        run(mk(2'd2, 3'b110, 0, 0, 0), {4{32'd100}}, {4{32'd7}}, {4{32'd3}});
        chk("R8 subtract", result_o, {4{32'd79}});

        // R9: wrap-around both ways.
        run(mk(2'd1, 3'b010, 0, 0, 0), '1, {8{16'd1}}, {8{16'd1}});
        chk("R9 wrap up", result_o, '0);
        run(mk(2'd3, 3'b110, 0, 0, 0), '0, {2{64'd1}}, {2{64'd1}});
        chk("R9 wrap down", result_o, '1);

        // R11: 64-bit lanes from 32-bit sources.
        run(mk(2'd3, 3'b011, 0, 0, 0), '0, '1, '1);
        chk("R11 64-bit lane", result_o, {2{64'hfffffffe00000001}});

        // R3/R4: malformed words.
        bad_op(mk(2'd1, 3'd0, 1, 2, 3) ^ 32'h0100_0000, "R3 major");
        bad_op(mk(2'd2, 3'd0, 1, 2, 3) | 32'h0020_0000, "R3 bit21");
        bad_op(mk(2'd3, 3'd5, 1, 2, 3) ^ 32'h0000_2000, "R3 minor");
        for (int v = 0; v < 8; v++)
            bad_op(mk(2'd0, 3'(v), 4, 5, 6), "R4 size0");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule